// File: doc/BRIEF.md
# Interpolation Rate Factor Decomposer

This block splits a requested total interpolation rate into a count of cascaded divide-by-two half-band stages and a residual rate for a CIC interpolator. A one-cycle start pulse loads a 32-bit rate into a small sequential engine. On each clock after the load, the engine removes one factor of two, as long as the working value is even and unused half-band stages remain. When no further halving is allowed, the leftover value becomes the CIC rate. The engine then presents the half-band count, the CIC rate, a packed configuration word, a range-error flag and the untouched total rate, and raises a one-cycle done strobe.

A control path uses it to work out and check filter-chain settings before they are programmed. The rules are greedy: half-band stages are consumed first, and the CIC stage takes whatever is left, clamped so that it is never zero. The block neither drives nor models the filters themselves.

Top module: `irf_decomposer`

## Requirements
- R1: While the working rate is even and the half-band count is below NUM_HB (default 3), each cycle increments the count by one and halves the working rate. After done, either the count equals NUM_HB, or bit number `hb_count_o` of `total_rate_o` is 1.
- R2: `cic_rate_o` is bits [7:0] of the leftover working rate, except that a value of 0 there is reported as 1 (rate 0 gives 3 half-bands and CIC 1, rate 2048 gives 3 and 1).
- R3: `err_o` is 1 exactly when the reported CIC rate lies outside 1..CIC_MAX (default 128). Rate 1024 gives CIC 128 with no error. Rates 129, 255 and 1032 are flagged.
- R4: `cfg_word_o` carries the half-band count in bits [15:8] and the CIC rate in bits [7:0].
- R5: `total_rate_o` presents the loaded 32-bit rate unchanged.
- R6: `done_o` is high for exactly one cycle, k+1 cycles after the clock edge that samples start, where k is the half-band count. All result outputs change only in that done cycle and hold afterwards. Examples: 1→(0,1), 6→(1,3), 12→(2,3), 13→(0,13).
- R7: A start pulse is ignored while `busy_o` is high, including in the cycle whose edge finishes the run. A start while idle is accepted and raises `busy_o` on the next cycle.
- R8: A synchronous active-high reset clears all result outputs, `done_o`, `err_o` and `busy_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load pulse for a new decomposition |
| rate_i | input | 32 | Requested total interpolation rate |
| busy_o | output | 1 | Decomposition in progress |
| done_o | output | 1 | One-cycle strobe when results update |
| hb_count_o | output | 8 | Number of half-band stages to enable |
| cic_rate_o | output | 8 | Residual CIC interpolation rate |
| cfg_word_o | output | 16 | Packed {half-band count, CIC rate} |
| total_rate_o | output | 32 | Loaded total rate, unchanged |
| err_o | output | 1 | CIC rate out of the allowed range |

## Verification
Two events can coincide: the engine's finishing edge and a new start request. The bench raises start in exactly the cycle whose edge ends a run. It then checks that the done strobe carries the old rate's results, that `busy_o` stays low afterwards, and that no second done appears. A separate test pulses start in the middle of a multi-step run with a different rate. It judges that the result and the latency both belong to the first request only.

// File: rtl/irf_pkg.sv
package irf_pkg;

  typedef enum logic [0:0] {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_t;

endpackage

// File: rtl/irf_halver.sv
module irf_halver #(
  parameter int RATE_W = 32,
  parameter int NUM_HB = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [RATE_W-1:0] rate,
  output logic              busy,
  output logic              finish,
  output logic [RATE_W-1:0] work,
  output logic [CNT_W-1:0]  count,
  output logic [RATE_W-1:0] total
);
  import irf_pkg::*;

  localparam logic [CNT_W-1:0] HB_LIMIT = CNT_W'(NUM_HB);

  eng_state_t state_q;
  logic       can_halve;

  // A halving step is legal when the value is even and stages remain.
  assign can_halve = (work[0] == 1'b0) && (count < HB_LIMIT);
  assign busy      = (state_q == ENG_RUN);
  assign finish    = busy && !can_halve;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENG_IDLE;
      work    <= '0;
      count   <= '0;
      total   <= '0;
    end else begin
      case (state_q)
        ENG_IDLE: begin
          if (start) begin
            state_q <= ENG_RUN;
            work    <= rate;
            count   <= '0;
            total   <= rate;
          end
        end
        ENG_RUN: begin
          if (can_halve) begin
            work  <= work >> 1;
            count <= count + 1'b1;
          end else begin
            state_q <= ENG_IDLE;
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/irf_cic_map.sv
module irf_cic_map #(
  parameter int RATE_W  = 32,
  parameter int CIC_W   = 8,
  parameter int CIC_MAX = 128
) (
  input  logic [RATE_W-1:0] work,
  output logic [CIC_W-1:0]  cic,
  output logic              bad
);
  localparam logic [CIC_W:0] MAX_EXT = (CIC_W+1)'(CIC_MAX);

  logic [CIC_W-1:0] raw;

  assign raw = work[CIC_W-1:0];

  always_comb begin
    cic = (raw == '0) ? CIC_W'(1) : raw;
    bad = ({1'b0, cic} > MAX_EXT) || (cic == '0);
  end

endmodule

// File: rtl/irf_result_reg.sv
module irf_result_reg #(
  parameter int RATE_W = 32,
  parameter int CNT_W  = 8,
  parameter int CIC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [CNT_W-1:0]  count,
  input  logic [CIC_W-1:0]  cic,
  input  logic              bad,
  input  logic [RATE_W-1:0] total,
  output logic              done,
  output logic [CNT_W-1:0]  hb_q,
  output logic [CIC_W-1:0]  cic_q,
  output logic [CNT_W+CIC_W-1:0] cfg_q,
  output logic [RATE_W-1:0] total_q,
  output logic              err_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      hb_q    <= '0;
      cic_q   <= '0;
      cfg_q   <= '0;
      total_q <= '0;
      err_q   <= 1'b0;
    end else begin
      done <= capture;
      if (capture) begin
        hb_q    <= count;
        cic_q   <= cic;
        cfg_q   <= {count, cic};
        total_q <= total;
        err_q   <= bad;
      end
    end
  end

endmodule

// File: rtl/irf_decomposer.sv
module irf_decomposer #(
  parameter int RATE_W  = 32,
  parameter int NUM_HB  = 3,
  parameter int CIC_MAX = 128,
  parameter int CNT_W   = 8,
  parameter int CIC_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic [RATE_W-1:0]      rate_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [CNT_W-1:0]       hb_count_o,
  output logic [CIC_W-1:0]       cic_rate_o,
  output logic [CNT_W+CIC_W-1:0] cfg_word_o,
  output logic [RATE_W-1:0]      total_rate_o,
  output logic                   err_o
);

  logic              eng_finish;
  logic [RATE_W-1:0] eng_work;
  logic [CNT_W-1:0]  eng_count;
  logic [RATE_W-1:0] eng_total;
  logic [CIC_W-1:0]  map_cic;
  logic              map_bad;

  irf_halver #(
    .RATE_W (RATE_W),
    .NUM_HB (NUM_HB),
    .CNT_W  (CNT_W)
  ) u_halver (
    .clk    (clk),
    .rst    (rst),
    .start  (start_i),
    .rate   (rate_i),
    .busy   (busy_o),
    .finish (eng_finish),
    .work   (eng_work),
    .count  (eng_count),
    .total  (eng_total)
  );

  irf_cic_map #(
    .RATE_W  (RATE_W),
    .CIC_W   (CIC_W),
    .CIC_MAX (CIC_MAX)
  ) u_map (
    .work (eng_work),
    .cic  (map_cic),
    .bad  (map_bad)
  );

  irf_result_reg #(
    .RATE_W (RATE_W),
    .CNT_W  (CNT_W),
    .CIC_W  (CIC_W)
  ) u_result (
    .clk     (clk),
    .rst     (rst),
    .capture (eng_finish),
    .count   (eng_count),
    .cic     (map_cic),
    .bad     (map_bad),
    .total   (eng_total),
    .done    (done_o),
    .hb_q    (hb_count_o),
    .cic_q   (cic_rate_o),
    .cfg_q   (cfg_word_o),
    .total_q (total_rate_o),
    .err_q   (err_o)
  );

endmodule

// File: rtl/irf_decomposer_chk.sv
module irf_decomposer_chk #(
  parameter int RATE_W  = 32,
  parameter int NUM_HB  = 3,
  parameter int CIC_MAX = 128,
  parameter int CNT_W   = 8,
  parameter int CIC_W   = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   start_i,
  input logic                   busy_o,
  input logic                   done_o,
  input logic [CNT_W-1:0]       hb_count_o,
  input logic [CIC_W-1:0]       cic_rate_o,
  input logic [CNT_W+CIC_W-1:0] cfg_word_o,
  input logic [RATE_W-1:0]      total_rate_o,
  input logic                   err_o
);

  function automatic logic [CIC_W-1:0] expect_cic(input logic [RATE_W-1:0] t,
                                                  input logic [CNT_W-1:0] n);
    logic [RATE_W-1:0] left;
    left = t >> n;
    return (left[CIC_W-1:0] == '0) ? CIC_W'(1) : left[CIC_W-1:0];
  endfunction

  // R1: halving stops only at an odd value or at the stage limit
  a_r1_stop_rule: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (hb_count_o == CNT_W'(NUM_HB)) || (total_rate_o[hb_count_o] == 1'b1));

  a_r1_hb_limit: assert property (@(posedge clk) disable iff (rst)
    hb_count_o <= CNT_W'(NUM_HB));

  // R2: CIC rate is the clamped leftover
  a_r2_cic_value: assert property (@(posedge clk) disable iff (rst)
    done_o |-> cic_rate_o == expect_cic(total_rate_o, hb_count_o));

  // R3: error flag tracks the range
  a_r3_err_range: assert property (@(posedge clk) disable iff (rst)
    done_o |-> err_o == (int'(cic_rate_o) > CIC_MAX || cic_rate_o == '0));

  // R4: packed word layout
  a_r4_cfg_layout: assert property (@(posedge clk) disable iff (rst)
    cfg_word_o == {hb_count_o, cic_rate_o});

  // R6: single-cycle strobe, results hold between strobes
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(hb_count_o) && $stable(cic_rate_o) &&
                $stable(total_rate_o) && $stable(err_o));

  // R7: idle start is taken; a start at the finishing edge is not
  a_r7_idle_accept: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> busy_o);

  a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R8: reset clears flags and results
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (!done_o && !err_o && !busy_o && hb_count_o == '0 &&
             cic_rate_o == '0 && total_rate_o == '0));

endmodule

bind irf_decomposer irf_decomposer_chk #(
  .RATE_W  (RATE_W),
  .NUM_HB  (NUM_HB),
  .CIC_MAX (CIC_MAX),
  .CNT_W   (CNT_W),
  .CIC_W   (CIC_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .hb_count_o   (hb_count_o),
  .cic_rate_o   (cic_rate_o),
  .cfg_word_o   (cfg_word_o),
  .total_rate_o (total_rate_o),
  .err_o        (err_o)
);

// File: tb/irf_decomposer_tb.sv
`timescale 1ns/1ps
module irf_decomposer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] rate_i = '0;
  logic        busy_o, done_o, err_o;
  logic [7:0]  hb_count_o, cic_rate_o;
  logic [15:0] cfg_word_o;
  logic [31:0] total_rate_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irf_decomposer u_dut (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .rate_i       (rate_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .hb_count_o   (hb_count_o),
    .cic_rate_o   (cic_rate_o),
    .cfg_word_o   (cfg_word_o),
    .total_rate_o (total_rate_o),
    .err_o        (err_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Start a run at a falling edge; return how many falling edges pass until done.
  task automatic launch_and_wait(input logic [31:0] r, output int waited);
    start_i = 1'b1;
    rate_i  = r;
    waited  = 0;
    @(negedge clk);
    start_i = 1'b0;
    waited  = 1;
    while (!done_o && waited < 20) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic run_rate(input logic [31:0] r, input int hb, input int cic, input bit bad);
    int waited;
    launch_and_wait(r, waited);
    check("R6 latency", waited, hb + 2);
    check("R6 done", done_o, 1);
    check("R1 hb count", hb_count_o, hb);
    check("R2 cic rate", cic_rate_o, cic);
    check("R3 error flag", err_o, bad);
    check("R4 cfg word", cfg_word_o, {8'(hb), 8'(cic)});
    check("R5 total rate", total_rate_o, r);
    @(negedge clk);
    check("R6 done pulse ends", done_o, 0);
    check("R6 results hold", cic_rate_o, cic);
  endtask

  task automatic t_reset;
    check("R8 done", done_o, 0);
    check("R8 busy", busy_o, 0);
    check("R8 err", err_o, 0);
    check("R8 cfg", cfg_word_o, 0);
    check("R8 total", total_rate_o, 0);
  endtask

  task automatic t_examples;
    run_rate(1, 0, 1, 0);
    run_rate(6, 1, 3, 0);
    run_rate(12, 2, 3, 0);
    run_rate(13, 0, 13, 0);
    run_rate(2, 1, 1, 0);
    run_rate(40, 3, 5, 0);
  endtask

  task automatic t_clamp;
    run_rate(0, 3, 1, 0);     // R2 zero leftover
    run_rate(2048, 3, 1, 0);  // R2 low byte zero
  endtask

  task automatic t_range;
    run_rate(1024, 3, 128, 0); // R3 at limit
    run_rate(129, 0, 129, 1);  // R3 just over
    run_rate(255, 0, 255, 1);
    run_rate(1032, 3, 129, 1);
  endtask

  task automatic t_busy_ignore;
    int waited;
    start_i = 1'b1; rate_i = 8;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    check("R7 busy mid-run", busy_o, 1);
    start_i = 1'b1; rate_i = 13;
    @(negedge clk);
    start_i = 1'b0;
    waited = 3;
    while (!done_o && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    check("R7 latency of first request", waited, 5);
    check("R7 hb of first request", hb_count_o, 3);
    check("R7 cic of first request", cic_rate_o, 1);
    check("R7 total of first request", total_rate_o, 8);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R7 no second done", done_o, 0);
    end
  endtask

  task automatic t_finish_collision;
    start_i = 1'b1; rate_i = 1;
    @(negedge clk);
    rate_i = 6;               // start held into the finishing edge
    @(negedge clk);
    start_i = 1'b0;
    check("R7 done at finish", done_o, 1);
    check("R7 old result kept", total_rate_o, 1);
    check("R7 busy stays low", busy_o, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R7 collision start dropped", done_o, 0);
    end
    run_rate(6, 1, 3, 0);     // idle start accepted afterwards
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_examples();
    t_clamp();
    t_range();
    t_busy_ignore();
    t_finish_collision();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule